// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Datapath

This block is the arithmetic heart of a signal-processing core. Each issued operation takes two 32-bit source words. Each word is viewed as a pair of 16-bit halves. The operation drives one of three datapath modes:

- **Dual mode** runs two independent 16x16 multiply-accumulate lanes, each feeding its own 40-bit accumulator. The 40 bits give 8 guard bits above a full 32-bit product.
- **Wide mode** performs a single 32x32 multiply-accumulate into a 72-bit accumulator formed by joining both lane accumulators.
- **Complex mode** treats the low half of each word as the real part and the high half as the imaginary part. Lane 0 gathers the real product and lane 1 the imaginary product.

Per-operation control bits select:
- signed or unsigned operands;
- the accumulator action (load, add, subtract, clear);
- round-half-up on write-back;
- clamping of the write-back word.

Accumulators and the two write-back words update on the clock edge that samples the issue. A sticky flag records every clamp that was applied.

Top module: `dmac_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `acc0`, `acc1`, `wb0`, `wb1`, `res_valid` and `sat_flag` are all zero.
- R2: Dual mode (`op_mode` 2'b00, and the spare code 2'b11 behaves the same) multiplies the low halves of `src_x` and `src_y` into lane 0 (`acc0`) and the high halves into lane 1 (`acc1`). Each product is sign-extended to 40 bits. `res_valid` is high exactly in the cycle after an issue.
- R3: `op_acc` selects the accumulator action: 2'b00 loads the product, 2'b01 adds it, 2'b10 subtracts it, and 2'b11 clears the accumulators to zero whatever the sources hold. Sums wrap modulo the accumulator width.
- R4: With `op_signed` low, the 16-bit halves (or, in wide mode, the 32-bit words) are zero-extended before multiplying. With `op_signed` high, they are sign-extended.
- R5: With `op_round` high in dual or complex mode, a lane's write-back starts from the accumulator plus 0x8000 with bits 15..0 cleared. With `op_round` low, it starts from the accumulator unchanged.
- R6: With `op_sat` high, a 40-bit value that does not fit 32 bits clamps on write-back. In signed mode it clamps to 0x7FFFFFFF when positive and 0x80000000 when negative. In unsigned mode it clamps to 0xFFFFFFFF when above range and 0x00000000 when bit 39 is set. With `op_sat` low, the write-back is bits 31..0.
- R7: `sat_flag` rises in the cycle after any applied clamp and stays high until reset.
- R8: Wide mode (`op_mode` 2'b01) accumulates the 64-bit product into the 72-bit value {acc1[31:0], acc0}. acc1[39:32] repeats bit 71. `wb0` is bits 31..0 of the (optionally rounded) value, and `wb1` is bits 71..32 passed through the R6 clamp.
- R9: In wide mode with `op_round` high, 2^31 is added to the 72-bit value and bits 31..0 are cleared before write-back. The accumulator itself is not rounded.
- R10: Complex mode (`op_mode` 2'b10) applies the R3 action to lane 0 with Re(x)Re(y) - Im(x)Im(y) and to lane 1 with Re(x)Im(y) + Im(x)Re(y). Re is bits 15..0 and Im is bits 31..16.
- R11: In a cycle without `issue`, the accumulators and write-back words hold their values and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| op_mode | input | 2 | 00 dual, 01 wide, 10 complex, 11 dual |
| op_acc | input | 2 | 00 load, 01 add, 10 subtract, 11 clear |
| op_signed | input | 1 | Treat operands as two's complement |
| op_round | input | 1 | Round on write-back |
| op_sat | input | 1 | Clamp on write-back |
| src_x | input | 32 | First source word (high and low halves) |
| src_y | input | 32 | Second source word (high and low halves) |
| acc0 | output | 40 | Lane 0 accumulator / low 40 bits of wide value |
| acc1 | output | 40 | Lane 1 accumulator / high 32 bits of wide value, sign-extended |
| wb0 | output | 32 | Lane 0 write-back word / low word in wide mode |
| wb1 | output | 32 | Lane 1 write-back word / clamped high word in wide mode |
| res_valid | output | 1 | Outputs carry the result of the previous cycle's issue |
| sat_flag | output | 1 | Sticky: a clamp has been applied since reset |

## Verification
The bound checker watches the control behaviour on every cycle:
- the one-cycle issue-to-valid timing;
- the hold of both accumulators when nothing is issued;
- zeroing by the clear action;
- the flag rising after every internal clamp event and never falling.

The arithmetic can only be shown by the bench's scenarios, which drive a behavioural reference through many value patterns:
- signed and unsigned products at the 16-bit extremes;
- accumulation reaching both clamp rails;
- round-half-up at exactly the half point and just below it;
- 32x32 wide products carried across the 40-bit lane boundary;
- complex products.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL  = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_CPLX  = 2'b10,
    MODE_DUAL2 = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_LOAD = 2'b00,
    ACT_ADD  = 2'b01,
    ACT_SUB  = 2'b10,
    ACT_CLR  = 2'b11
  } act_e;

  typedef struct packed {
    mode_e mode;
    act_e  act;
    logic  sgn;
    logic  rnd;
    logic  sat;
  } ctrl_t;

endpackage

// File: rtl/dmac_pp_array.sv
// Four half-word partial-product multipliers shared by all modes.
// pp[0] = xl*yl, pp[1] = xh*yh, pp[2] = xl*yh, pp[3] = xh*yl
module dmac_pp_array #(
  parameter int HALF_W = 16,
  localparam int OPW = 2 * HALF_W,
  localparam int EXW = HALF_W + 1,
  localparam int PPW = 2 * EXW
) (
  input  logic [OPW-1:0]        x_op,
  input  logic [OPW-1:0]        y_op,
  input  logic                  sgn,
  input  logic                  wide,
  output logic signed [PPW-1:0] pp [4]
);

  function automatic logic signed [EXW-1:0] ext_half(input logic [HALF_W-1:0] h,
                                                     input logic se);
    return {se & h[HALF_W-1], h};
  endfunction

  logic [HALF_W-1:0] xl, xh, yl, yh;
  logic              lo_se;
  logic signed [EXW-1:0] a_op [4];
  logic signed [EXW-1:0] b_op [4];

  assign xl = x_op[HALF_W-1:0];
  assign xh = x_op[OPW-1:HALF_W];
  assign yl = y_op[HALF_W-1:0];
  assign yh = y_op[OPW-1:HALF_W];
  // In wide mode the low halves are magnitude digits of a 32-bit word.
  assign lo_se = sgn & ~wide;

  always_comb begin
    a_op[0] = ext_half(xl, lo_se);  b_op[0] = ext_half(yl, lo_se);
    a_op[1] = ext_half(xh, sgn);    b_op[1] = ext_half(yh, sgn);
    a_op[2] = ext_half(xl, lo_se);  b_op[2] = ext_half(yh, sgn);
    a_op[3] = ext_half(xh, sgn);    b_op[3] = ext_half(yl, lo_se);
  end

  for (genvar g = 0; g < 4; g++) begin : g_mul
    assign pp[g] = a_op[g] * b_op[g];
  end

endmodule

// File: rtl/dmac_rounder.sv
// Round-half-up at bit POS: add 2^(POS-1), clear the bits below POS.
module dmac_rounder #(
  parameter int W   = 40,
  parameter int POS = 16
) (
  input  logic signed [W-1:0] v_in,
  input  logic                en,
  output logic signed [W-1:0] v_out
);

  localparam logic [W-1:0] HALF_LSB = W'(1) << (POS - 1);
  localparam logic [W-1:0] KEEP     = ~((W'(1) << POS) - W'(1));

  logic [W-1:0] sum;

  assign sum   = v_in + HALF_LSB;
  assign v_out = en ? signed'(sum & KEEP) : v_in;

endmodule

// File: rtl/dmac_wb_sat.sv
// Write-back clamp of a wide accumulator value to a word.
module dmac_wb_sat #(
  parameter int IN_W  = 40,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0] v_in,
  input  logic                   sgn,
  input  logic                   sat_en,
  output logic [OUT_W-1:0]       w_out,
  output logic                   clamp
);

  logic [IN_W-OUT_W:0]   top_s;
  logic [IN_W-OUT_W-1:0] top_u;
  logic                  fits;
  logic [OUT_W-1:0]      rail;

  assign top_s = v_in[IN_W-1:OUT_W-1];
  assign top_u = v_in[IN_W-1:OUT_W];
  assign fits  = sgn ? ((&top_s) | ~(|top_s)) : ~(|top_u);

  always_comb begin
    if (sgn) rail = v_in[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    else     rail = v_in[IN_W-1] ? '0 : '1;
  end

  assign clamp = sat_en & ~fits;
  assign w_out = clamp ? rail : v_in[OUT_W-1:0];

endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              issue,
  input  logic [1:0]                        op_mode,
  input  logic [1:0]                        op_acc,
  input  logic                              op_signed,
  input  logic                              op_round,
  input  logic                              op_sat,
  input  logic [2*HALF_W-1:0]               src_x,
  input  logic [2*HALF_W-1:0]               src_y,
  output logic [2*HALF_W+GUARD_W-1:0]       acc0,
  output logic [2*HALF_W+GUARD_W-1:0]       acc1,
  output logic [2*HALF_W-1:0]               wb0,
  output logic [2*HALF_W-1:0]               wb1,
  output logic                              res_valid,
  output logic                              sat_flag
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = WORD_W + GUARD_W;
  localparam int WIDE_W = ACC_W + WORD_W;
  localparam int PPW    = 2 * (HALF_W + 1);

  // ---------------- arithmetic helpers ----------------
  function automatic logic signed [ACC_W-1:0] apply_lane(input logic signed [ACC_W-1:0] cur,
                                                         input logic signed [ACC_W-1:0] term,
                                                         input act_e act);
    case (act)
      ACT_LOAD: return term;
      ACT_ADD:  return cur + term;
      ACT_SUB:  return cur - term;
      default:  return '0;
    endcase
  endfunction

  function automatic logic signed [WIDE_W-1:0] apply_wide(input logic signed [WIDE_W-1:0] cur,
                                                          input logic signed [WIDE_W-1:0] term,
                                                          input act_e act);
    case (act)
      ACT_LOAD: return term;
      ACT_ADD:  return cur + term;
      ACT_SUB:  return cur - term;
      default:  return '0;
    endcase
  endfunction

  // ---------------- control decode ----------------
  ctrl_t ctl;
  logic  wide_m, cplx_m;

  assign ctl.mode = mode_e'(op_mode);
  assign ctl.act  = act_e'(op_acc);
  assign ctl.sgn  = op_signed;
  assign ctl.rnd  = op_round;
  assign ctl.sat  = op_sat;
  assign wide_m   = (ctl.mode == MODE_WIDE);
  assign cplx_m   = (ctl.mode == MODE_CPLX);

  // ---------------- partial products ----------------
  logic signed [PPW-1:0] pp [4];

  dmac_pp_array #(.HALF_W(HALF_W)) u_pp (
    .x_op (src_x),
    .y_op (src_y),
    .sgn  (ctl.sgn),
    .wide (wide_m),
    .pp   (pp)
  );

  // ---------------- state ----------------
  logic signed [ACC_W-1:0] acc_q [2];
  logic [WORD_W-1:0]       wb_q  [2];
  logic                    vld_q, flag_q;

  // ---------------- lane terms ----------------
  logic signed [ACC_W-1:0] pp_l  [4];
  logic signed [ACC_W-1:0] term  [2];
  logic signed [ACC_W-1:0] nxt   [2];

  always_comb begin
    for (int i = 0; i < 4; i++) pp_l[i] = ACC_W'(pp[i]);
    if (cplx_m) begin
      term[0] = pp_l[0] - pp_l[1];
      term[1] = pp_l[2] + pp_l[3];
    end else begin
      term[0] = pp_l[0];
      term[1] = pp_l[1];
    end
    for (int i = 0; i < 2; i++) nxt[i] = apply_lane(acc_q[i], term[i], ctl.act);
  end

  // ---------------- wide term ----------------
  logic signed [WIDE_W-1:0] w_ll, w_hh, w_mid, w_prod, w_cur, w_nxt, w_rnd;

  always_comb begin
    w_ll   = WIDE_W'(pp[0]);
    w_hh   = WIDE_W'(pp[1]);
    w_mid  = WIDE_W'(pp[2]) + WIDE_W'(pp[3]);
    w_prod = w_ll + (w_mid <<< HALF_W) + (w_hh <<< WORD_W);
    w_cur  = {acc_q[1][WORD_W-1:0], acc_q[0]};
    w_nxt  = apply_wide(w_cur, w_prod, ctl.act);
  end

  dmac_rounder #(.W(WIDE_W), .POS(WORD_W)) u_rnd_wide (
    .v_in  (w_nxt),
    .en    (ctl.rnd),
    .v_out (w_rnd)
  );

  // ---------------- per-lane round and clamp ----------------
  logic signed [ACC_W-1:0] rnd_v  [2];
  logic signed [ACC_W-1:0] sat_in [2];
  logic [WORD_W-1:0]       sat_out[2];
  logic                    clamp  [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dmac_rounder #(.W(ACC_W), .POS(HALF_W)) u_rnd (
      .v_in  (nxt[g]),
      .en    (ctl.rnd),
      .v_out (rnd_v[g])
    );
    dmac_wb_sat #(.IN_W(ACC_W), .OUT_W(WORD_W)) u_sat (
      .v_in   (sat_in[g]),
      .sgn    (ctl.sgn),
      .sat_en (ctl.sat),
      .w_out  (sat_out[g]),
      .clamp  (clamp[g])
    );
  end

  always_comb begin
    sat_in[0] = rnd_v[0];
    sat_in[1] = wide_m ? w_rnd[WIDE_W-1:WORD_W] : rnd_v[1];
  end

  // ---------------- next-state selection ----------------
  logic signed [ACC_W-1:0] acc_d [2];
  logic [WORD_W-1:0]       wb_d  [2];
  logic                    ovf_event;

  always_comb begin
    if (wide_m) begin
      acc_d[0] = w_nxt[ACC_W-1:0];
      acc_d[1] = {{GUARD_W{w_nxt[WIDE_W-1]}}, w_nxt[WIDE_W-1:ACC_W]};
      wb_d[0]  = w_rnd[WORD_W-1:0];
    end else begin
      acc_d[0] = nxt[0];
      acc_d[1] = nxt[1];
      wb_d[0]  = sat_out[0];
    end
    wb_d[1] = sat_out[1];
  end

  assign ovf_event = issue & ((clamp[0] & ~wide_m) | clamp[1]);

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
      wb_q[0]  <= '0;
      wb_q[1]  <= '0;
      vld_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      vld_q <= issue;
      if (issue) begin
        acc_q[0] <= acc_d[0];
        acc_q[1] <= acc_d[1];
        wb_q[0]  <= wb_d[0];
        wb_q[1]  <= wb_d[1];
      end
      if (ovf_event) flag_q <= 1'b1;
    end
  end

  assign acc0      = acc_q[0];
  assign acc1      = acc_q[1];
  assign wb0       = wb_q[0];
  assign wb1       = wb_q[1];
  assign res_valid = vld_q;
  assign sat_flag  = flag_q;

endmodule

// File: rtl/dmac_unit_chk.sv
module dmac_unit_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [1:0]       op_acc,
  input logic [ACC_W-1:0] acc0,
  input logic [ACC_W-1:0] acc1,
  input logic             res_valid,
  input logic             sat_flag,
  input logic             ovf_event
);

  // R2
  issue_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> res_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!res_valid && $stable(acc0) && $stable(acc1)));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_acc == 2'b11) |=> (acc0 == '0 && acc1 == '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);

  // R6
  clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> sat_flag);

endmodule

bind dmac_unit dmac_unit_chk #(.ACC_W(2*HALF_W+GUARD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue     (issue),
  .op_acc    (op_acc),
  .acc0      (acc0),
  .acc1      (acc1),
  .res_valid (res_valid),
  .sat_flag  (sat_flag),
  .ovf_event (ovf_event)
);

// File: tb/dmac_unit_test.sv
module dmac_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [1:0]  op_mode = '0, op_acc = '0;
  logic        op_signed = 1'b0, op_round = 1'b0, op_sat = 1'b0;
  logic [31:0] src_x = '0, src_y = '0;
  logic [39:0] acc0, acc1;
  logic [31:0] wb0, wb1;
  logic        res_valid, sat_flag;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  // behavioural reference state
  logic signed [39:0] m_a0 = '0, m_a1 = '0;
  logic [31:0]        m_w0 = '0, m_w1 = '0;
  logic               m_v = 1'b0, m_f = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_mode(op_mode), .op_acc(op_acc),
    .op_signed(op_signed), .op_round(op_round), .op_sat(op_sat),
    .src_x(src_x), .src_y(src_y), .acc0(acc0), .acc1(acc1),
    .wb0(wb0), .wb1(wb1), .res_valid(res_valid), .sat_flag(sat_flag)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [39:0] h2v(input logic [15:0] h, input logic s);
    return s ? {{24{h[15]}}, h} : {24'b0, h};
  endfunction

  function automatic logic [31:0] m_clamp(input logic signed [39:0] v, input logic s,
                                          input logic en, output logic hit);
    longint lv;
    logic [31:0] r;
    lv  = longint'(v);
    r   = v[31:0];
    hit = 1'b0;
    if (s) begin
      if (lv > 64'sd2147483647)       begin r = 32'h7FFFFFFF; hit = en; end
      else if (lv < -64'sd2147483648) begin r = 32'h80000000; hit = en; end
    end else begin
      if (lv < 0)                     begin r = 32'h00000000; hit = en; end
      else if (lv > 64'sd4294967295)  begin r = 32'hFFFFFFFF; hit = en; end
    end
    return en ? r : v[31:0];
  endfunction

  function automatic logic signed [39:0] m_round16(input logic signed [39:0] v);
    longint t;
    t = longint'(v) + 64'sd32768;
    t = t & ~64'sh000000000000FFFF;
    return t[39:0];
  endfunction

  task automatic model(input logic iss, input logic [1:0] md, input logic [1:0] ac,
                       input logic s, input logic r, input logic st,
                       input logic [31:0] x, input logic [31:0] y);
    logic signed [39:0] t0, t1, n0, n1;
    logic signed [71:0] X, Y, P, cur, nw;
    logic [71:0] rw;
    logic h0, h1;
    m_v = iss;
    if (!iss) return;
    if (md == 2'b01) begin
      X   = s ? {{40{x[31]}}, x} : {40'b0, x};
      Y   = s ? {{40{y[31]}}, y} : {40'b0, y};
      P   = X * Y;
      cur = {m_a1[31:0], m_a0};
      case (ac)
        2'b00: nw = P;
        2'b01: nw = cur + P;
        2'b10: nw = cur - P;
        default: nw = '0;
      endcase
      m_a0 = nw[39:0];
      m_a1 = {{8{nw[71]}}, nw[71:40]};
      rw   = nw;
      if (r) rw = (rw + (72'd1 << 31)) & ~72'hFFFFFFFF;
      m_w0 = rw[31:0];
      m_w1 = m_clamp(rw[71:32], s, st, h1);
      if (h1) m_f = 1'b1;
    end else begin
      if (md == 2'b10) begin
        t0 = h2v(x[15:0], s) * h2v(y[15:0], s) - h2v(x[31:16], s) * h2v(y[31:16], s);
        t1 = h2v(x[15:0], s) * h2v(y[31:16], s) + h2v(x[31:16], s) * h2v(y[15:0], s);
      end else begin
        t0 = h2v(x[15:0], s) * h2v(y[15:0], s);
        t1 = h2v(x[31:16], s) * h2v(y[31:16], s);
      end
      case (ac)
        2'b00: begin n0 = t0; n1 = t1; end
        2'b01: begin n0 = m_a0 + t0; n1 = m_a1 + t1; end
        2'b10: begin n0 = m_a0 - t0; n1 = m_a1 - t1; end
        default: begin n0 = '0; n1 = '0; end
      endcase
      m_a0 = n0;
      m_a1 = n1;
      if (r) begin n0 = m_round16(n0); n1 = m_round16(n1); end
      m_w0 = m_clamp(n0, s, st, h0);
      m_w1 = m_clamp(n1, s, st, h1);
      if (h0 || h1) m_f = 1'b1;
    end
  endtask

  task automatic compare_all(input string tag);
    cmp(tag, "acc0", {32'b0, acc0}, {32'b0, m_a0});
    cmp(tag, "acc1", {32'b0, acc1}, {32'b0, m_a1});
    cmp(tag, "wb0", {40'b0, wb0}, {40'b0, m_w0});
    cmp(tag, "wb1", {40'b0, wb1}, {40'b0, m_w1});
    cmp(tag, "res_valid", {71'b0, res_valid}, {71'b0, m_v});
    cmp(tag, "sat_flag", {71'b0, sat_flag}, {71'b0, m_f});
  endtask

  // drive one cycle, step the reference, compare a quarter period after the edge
  task automatic op(input string tag, input logic iss, input logic [1:0] md,
                    input logic [1:0] ac, input logic s, input logic r, input logic st,
                    input logic [31:0] x, input logic [31:0] y);
    issue = iss; op_mode = md; op_acc = ac; op_signed = s;
    op_round = r; op_sat = st; src_x = x; src_y = y;
    model(iss, md, ac, s, r, st, x, y);
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    op(tag, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h12345678);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare_all("R1 after release");

    // R2 dual signed, both mode codes
    op("R2 dual load", 1, 2'b00, 2'b00, 1, 0, 0, {16'hFFFD, 16'd1000}, {16'd7, 16'hFFEC});
    op("R2 dual alt code", 1, 2'b11, 2'b01, 1, 0, 0, {16'h8000, 16'h7FFF}, {16'h8000, 16'h8000});
    // R3 actions
    op("R3 add", 1, 2'b00, 2'b01, 1, 0, 0, {16'd300, 16'hFF00}, {16'd5, 16'd9});
    op("R3 sub", 1, 2'b00, 2'b10, 1, 0, 0, {16'd1234, 16'd4321}, {16'hFFFF, 16'd17});
    op("R3 clear", 1, 2'b00, 2'b11, 1, 1, 1, 32'h7FFF7FFF, 32'h7FFF7FFF);
    op("R3 sub from zero", 1, 2'b00, 2'b10, 1, 0, 0, {16'd3, 16'd2}, {16'd4, 16'd5});
    // R11 idle
    idle("R11 idle a");
    idle("R11 idle b");
    // R4 unsigned extremes
    op("R4 unsigned load", 1, 2'b00, 2'b00, 0, 0, 0, 32'hFFFF8000, 32'hFFFF8001);
    op("R4 signed same bits", 1, 2'b00, 2'b00, 1, 0, 0, 32'hFFFF8000, 32'hFFFF8001);
    // R5 rounding at and just below the half point
    op("R5 load 0x18000", 1, 2'b00, 2'b00, 0, 1, 0, 32'h00000003, 32'h00008000);
    op("R5 below half", 1, 2'b00, 2'b10, 0, 1, 0, 32'h00000001, 32'h00000001);
    op("R5 negative round", 1, 2'b00, 2'b00, 1, 1, 0, {16'hFFFD, 16'hFFFD}, {16'h8000, 16'h8000});
    // R6 unclamped wrap then clamp at both rails, R7 flag
    op("R6 pos load", 1, 2'b00, 2'b00, 1, 0, 0, 32'h7FFF8000, 32'h7FFF7FFF);
    op("R6 pos add", 1, 2'b00, 2'b01, 1, 0, 0, 32'h7FFF8000, 32'h7FFF7FFF);
    op("R6 wrap no sat", 1, 2'b00, 2'b01, 1, 0, 0, 32'h7FFF8000, 32'h7FFF7FFF);
    op("R6 clamp both", 1, 2'b00, 2'b01, 1, 0, 1, 32'h7FFF8000, 32'h7FFF7FFF);
    idle("R7 flag holds");
    op("R7 flag after clear", 1, 2'b00, 2'b11, 1, 0, 0, 32'h0, 32'h0);
    op("R6 unsigned load", 1, 2'b00, 2'b00, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R6 unsigned add", 1, 2'b00, 2'b01, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R6 unsigned under", 1, 2'b00, 2'b10, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R6 unsigned neg", 1, 2'b00, 2'b10, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R8 wide mode
    op("R8 wide signed load", 1, 2'b01, 2'b00, 1, 0, 0, 32'hF8A432EB, 32'd987654321);
    op("R8 wide signed add", 1, 2'b01, 2'b01, 1, 0, 1, 32'h80000000, 32'h80000000);
    op("R8 wide unsigned", 1, 2'b01, 2'b00, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R8 wide unsigned add", 1, 2'b01, 2'b01, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R8 wide sub", 1, 2'b01, 2'b10, 1, 0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    idle("R11 idle wide");
    // R9 wide rounding
    op("R9 wide round up", 1, 2'b01, 2'b00, 0, 1, 0, 32'h00000001, 32'h80000000);
    op("R9 wide below half", 1, 2'b01, 2'b10, 0, 1, 0, 32'h00000001, 32'h00000001);
    // R10 complex
    op("R10 cplx load", 1, 2'b10, 2'b00, 1, 0, 0, {16'd4, 16'd3}, {16'hFFFE, 16'd5});
    op("R10 cplx add", 1, 2'b10, 2'b01, 1, 0, 0, {16'h8000, 16'h7FFF}, {16'h8000, 16'h8000});
    op("R10 cplx sub rnd", 1, 2'b10, 2'b10, 1, 1, 1, {16'h1234, 16'hABCD}, {16'h7FFF, 16'h8001});
    op("R10 cplx unsigned", 1, 2'b10, 2'b00, 0, 0, 0, {16'hFFFF, 16'h0002}, {16'h0003, 16'hFFFF});
    idle("R11 idle end");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule